// File: doc/BRIEF.md
# Zero-Fill and Copy DMA Mover

A background bulk-transfer engine that moves data in aligned 16-byte beats (128 bits per beat). A requester hands it a source address, a destination address and a beat count, all in 16-byte units, plus a 2-bit direction code, through a valid/ready start handshake. Two direction codes copy beats out of a local scratchpad. The other two send all-zero beats and never read the scratchpad.

The destination is either the scratchpad itself or a 32-bit configuration/instruction window. For window directions the destination is remapped. Low destinations land in the configuration region and high ones land in the instruction-RAM region. A destination in the hole between the two regions is dropped: the transfer finishes without any traffic. Scratchpad reads and writes advance only in cycles where the shared grant input is high. Window writes need no grant and are accepted one per cycle. Copies are paced so that at most eight reads and eight writes happen in any 11-cycle frame.

Top module: `zfill_copy_mover`

## Requirements
- R1: `start_ready` is high exactly when `busy` is low. A start is accepted in a cycle where `start_valid` and `start_ready` are both high, and `busy` rises in the next cycle. A start presented while `busy` is high has no effect.
- R2: Direction code 0 zero-fills the scratchpad, 1 copies scratchpad to window, 2 zero-fills the window, and 3 copies scratchpad to scratchpad. Zero-fill directions (codes 0 and 2) never raise `sp_rd_req`, and every beat they write is all zeros.
- R3: For codes 1 and 2, a destination unit at or below 0x0FFF writes window byte address 0xFFEF0000 + 16*dst. The address grows by 16 on each beat, so unit 0x0FFF maps to 0xFFEFFFF0.
- R4: For codes 1 and 2, a destination unit at or above 0x4000 writes window byte address 0xFFC00000 + 16*dst - 0x40000, so unit 0x4000 maps to 0xFFC00000.
- R5: For codes 1 and 2, a destination unit from 0x1000 to 0x3FFF is dropped. The start is accepted, `busy` never rises, and no read or write is issued.
- R6: In copy directions (codes 1 and 3), the first busy cycle opens an 11-cycle frame. Each frame allows at most 8 granted reads and 8 accepted writes. Read data is taken from `sp_rd_data` in the cycle after a granted read. Beats are written in read order. A 20-beat copy with the grant held high keeps `busy` up for 28 cycles, and a 10-beat copy keeps it up for 15.
- R7: A scratchpad read or write is taken only in a cycle with `sp_gnt` high. While the grant is low, the request, its address and its data hold. Window writes proceed one per cycle whatever the grant.
- R8: `busy` falls in the cycle after the last write is accepted. `outstanding` is high while a granted read has not yet returned data or read data waits in the engine to be written.
- R9: A start with a size of zero is accepted and completes with no memory traffic and without `busy` rising.
- R10: A scratchpad zero-fill (code 0) writes one beat per granted cycle, so an N-beat fill with the grant held high keeps `busy` up for N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Start request |
| start_ready | output | 1 | Engine can accept a start |
| start_src | input | UNIT_AW | Source scratchpad address, 16-byte units |
| start_dst | input | UNIT_AW | Destination address, 16-byte units |
| start_size | input | SIZE_W | Transfer length in beats |
| start_dir | input | 2 | Direction code |
| sp_gnt | input | 1 | Scratchpad port grant for this cycle |
| sp_rd_req | output | 1 | Scratchpad read request |
| sp_rd_addr | output | UNIT_AW | Scratchpad read address, 16-byte units |
| sp_rd_data | input | DATA_W | Read data, valid the cycle after a granted read |
| sp_wr_req | output | 1 | Scratchpad write request |
| sp_wr_addr | output | UNIT_AW | Scratchpad write address, 16-byte units |
| sp_wr_data | output | DATA_W | Scratchpad write data |
| win_wr_req | output | 1 | Window write, always accepted |
| win_wr_addr | output | ADDR_W | Window byte address |
| win_wr_data | output | DATA_W | Window write data |
| busy | output | 1 | Transfer in progress |
| outstanding | output | 1 | Read in flight or read data buffered |

## Verification
The properties assume that the scratchpad returns read data exactly one cycle after a granted read. They also assume that copy source and destination ranges never overlap, so no read sees a write of the same transfer. The grant is one shared signal for both scratchpad ports and may toggle freely. The stimulus sets up copies on disjoint regions only, and the bench memory answers each granted read with a registered value on the next edge. The grant is driven as always high, always low, or a pseudo-random bit.

// File: rtl/mover_pkg.sv
// Shared types for the zero-fill/copy mover.
// Assumes the direction code is two bits, with bit 0 meaning "source is the scratchpad".
package mover_pkg;

    typedef enum logic [1:0] {
        DIR_ZERO_TO_SP  = 2'd0,
        DIR_SP_TO_WIN   = 2'd1,
        DIR_ZERO_TO_WIN = 2'd2,
        DIR_SP_TO_SP    = 2'd3
    } mover_dir_e;

    // True when the direction reads beats from the scratchpad.
    function automatic logic dir_reads_sp(mover_dir_e d);
        return d[0];
    endfunction

    // True when the direction writes into the config/instruction window.
    function automatic logic dir_hits_win(mover_dir_e d);
        return d[0] ^ d[1];
    endfunction

endpackage

// File: rtl/mover_window_map.sv
// Maps a destination in 16-byte units to a window byte address.
// Low units go to the configuration region and high units to the instruction region.
// Units in between raise drop. Purely combinational; assumes ADDR_W > UNIT_AW + 4.
module mover_window_map #(
    parameter int              UNIT_AW     = 16,
    parameter int              ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] CFG_BASE    = 32'hFFEF_0000,
    parameter logic [ADDR_W-1:0] CFG_BYTES   = 32'h0001_0000,
    parameter logic [ADDR_W-1:0] IRAM_BASE   = 32'hFFC0_0000,
    parameter logic [ADDR_W-1:0] IRAM_OFFSET = 32'h0004_0000
) (
    input  logic [UNIT_AW-1:0] dst_unit,
    output logic [ADDR_W-1:0]  win_base,
    output logic               drop
);
    localparam logic [ADDR_W-1:0]  CFG_LAST_W  = (CFG_BYTES >> 4) - 1;
    localparam logic [ADDR_W-1:0]  IRAM_FIRST_W = IRAM_OFFSET >> 4;
    localparam logic [UNIT_AW-1:0] CFG_LAST    = CFG_LAST_W[UNIT_AW-1:0];
    localparam logic [UNIT_AW-1:0] IRAM_FIRST  = IRAM_FIRST_W[UNIT_AW-1:0];

    logic [ADDR_W-1:0] byte_addr;
    assign byte_addr = {{(ADDR_W-UNIT_AW-4){1'b0}}, dst_unit, 4'b0000};

    // Pick the region and compute its byte address.
    always_comb begin
        drop     = 1'b0;
        win_base = '0;
        if (dst_unit <= CFG_LAST) begin
            win_base = CFG_BASE + byte_addr;
        end else if (dst_unit >= IRAM_FIRST) begin
            win_base = IRAM_BASE + byte_addr - IRAM_OFFSET;
        end else begin
            drop = 1'b1;
        end
    end
endmodule

// File: rtl/mover_pacer.sv
// Frame pacer for copy transfers. A frame of FRAME_LEN cycles starts at restart.
// Within a frame, at most FRAME_RD reads and FRAME_WR writes are permitted.
// Counts run only while active is high.
module mover_pacer #(
    parameter int FRAME_LEN = 11,
    parameter int FRAME_RD  = 8,
    parameter int FRAME_WR  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic active,
    input  logic rd_fire,
    input  logic wr_fire,
    output logic rd_ok,
    output logic wr_ok
);
    localparam int FW   = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam int CMAX = (FRAME_RD > FRAME_WR) ? FRAME_RD : FRAME_WR;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [FW-1:0] LAST = FW'(FRAME_LEN - 1);

    logic [FW-1:0] frame_pos;
    logic [CW-1:0] rd_cnt, wr_cnt;

    assign rd_ok = rd_cnt < CW'(FRAME_RD);
    assign wr_ok = wr_cnt < CW'(FRAME_WR);

    // Advance the frame position and the per-frame access counts.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            frame_pos <= '0;
            rd_cnt    <= '0;
            wr_cnt    <= '0;
        end else if (active) begin
            if (frame_pos == LAST) begin
                frame_pos <= '0;
                rd_cnt    <= '0;
                wr_cnt    <= '0;
            end else begin
                frame_pos <= frame_pos + 1'b1;
                rd_cnt    <= rd_cnt + CW'(rd_fire);
                wr_cnt    <= wr_cnt + CW'(wr_fire);
            end
        end
    end
endmodule

// File: rtl/mover_beat_buf.sv
// Small FIFO holding read beats until they are written. Push and pop may coincide.
// Assumes the caller never pushes when full or pops when empty.
module mover_beat_buf #(
    parameter int DATA_W = 128,
    parameter int DEPTH  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DATA_W-1:0]          push_data,
    input  logic                       pop,
    output logic [DATA_W-1:0]          head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DATA_W-1:0] slots [DEPTH];
    logic [PW-1:0]     rd_ptr, wr_ptr;

    assign head = slots[rd_ptr];

    // Move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Store an incoming beat.
    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/zfill_copy_mover.sv
// Zero-fill/copy mover top. It accepts a transfer on start_valid while idle.
// Copy directions read the scratchpad and buffer the beats. Zero-fill directions write zeros.
// Window directions remap the destination and drop it when it falls in the hole.
// Assumes read data arrives on sp_rd_data the cycle after a granted read.
module zfill_copy_mover
    import mover_pkg::*;
#(
    parameter int              UNIT_AW     = 16,
    parameter int              SIZE_W      = 16,
    parameter int              DATA_W      = 128,
    parameter int              ADDR_W      = 32,
    parameter int              BUF_DEPTH   = 8,
    parameter int              FRAME_LEN   = 11,
    parameter int              FRAME_RD    = 8,
    parameter int              FRAME_WR    = 8,
    parameter logic [ADDR_W-1:0] CFG_BASE    = 32'hFFEF_0000,
    parameter logic [ADDR_W-1:0] CFG_BYTES   = 32'h0001_0000,
    parameter logic [ADDR_W-1:0] IRAM_BASE   = 32'hFFC0_0000,
    parameter logic [ADDR_W-1:0] IRAM_OFFSET = 32'h0004_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_valid,
    output logic               start_ready,
    input  logic [UNIT_AW-1:0] start_src,
    input  logic [UNIT_AW-1:0] start_dst,
    input  logic [SIZE_W-1:0]  start_size,
    input  logic [1:0]         start_dir,
    input  logic               sp_gnt,
    output logic               sp_rd_req,
    output logic [UNIT_AW-1:0] sp_rd_addr,
    input  logic [DATA_W-1:0]  sp_rd_data,
    output logic               sp_wr_req,
    output logic [UNIT_AW-1:0] sp_wr_addr,
    output logic [DATA_W-1:0]  sp_wr_data,
    output logic               win_wr_req,
    output logic [ADDR_W-1:0]  win_wr_addr,
    output logic [DATA_W-1:0]  win_wr_data,
    output logic               busy,
    output logic               outstanding
);
    localparam int CNT_W = $clog2(BUF_DEPTH + 1);

    logic               busy_q;
    mover_dir_e         dir_q;
    logic [UNIT_AW-1:0] rd_addr_q, wr_unit_q;
    logic [ADDR_W-1:0]  win_addr_q;
    logic [SIZE_W-1:0]  rd_left_q, wr_left_q;
    logic               inflight_q;

    logic [ADDR_W-1:0]  map_base;
    logic               map_drop;
    mover_dir_e         start_kind;
    logic               accept, launch;

    logic               reads_sp, to_win;
    logic [DATA_W-1:0]  buf_head;
    logic [CNT_W-1:0]   buf_cnt;
    logic [CNT_W:0]     pending;
    logic               pace_rd_ok, pace_wr_ok;
    logic               rd_go, rd_fire, wr_src_ok, wr_go, wr_fire, last_wr;
    logic [DATA_W-1:0]  beat_data;

    mover_window_map #(
        .UNIT_AW(UNIT_AW), .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE),
        .CFG_BYTES(CFG_BYTES), .IRAM_BASE(IRAM_BASE), .IRAM_OFFSET(IRAM_OFFSET)
    ) i_map (
        .dst_unit(start_dst),
        .win_base(map_base),
        .drop    (map_drop)
    );

    // Decide whether a start is taken, and whether it produces any traffic.
    assign start_kind = mover_dir_e'(start_dir);
    assign accept     = start_valid & ~busy_q;
    assign launch     = accept & (start_size != '0) & ~(dir_hits_win(start_kind) & map_drop);

    assign reads_sp = dir_reads_sp(dir_q);
    assign to_win   = dir_hits_win(dir_q);

    // Read issue: within the frame budget, and with buffer room for the beat in flight.
    assign pending = {1'b0, buf_cnt} + (CNT_W+1)'(inflight_q);
    assign rd_go   = busy_q & reads_sp & (rd_left_q != '0) & pace_rd_ok
                   & (pending < (CNT_W+1)'(BUF_DEPTH));
    assign rd_fire = rd_go & sp_gnt;

    // Write issue: copy needs a buffered beat and budget, zero-fill is always ready.
    assign wr_src_ok = reads_sp ? ((buf_cnt != '0) & pace_wr_ok) : 1'b1;
    assign wr_go     = busy_q & (wr_left_q != '0) & wr_src_ok;
    assign wr_fire   = wr_go & (to_win | sp_gnt);
    assign last_wr   = wr_fire & (wr_left_q == SIZE_W'(1));
    assign beat_data = reads_sp ? buf_head : '0;

    mover_pacer #(
        .FRAME_LEN(FRAME_LEN), .FRAME_RD(FRAME_RD), .FRAME_WR(FRAME_WR)
    ) i_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(launch),
        .active (busy_q & reads_sp),
        .rd_fire(rd_fire),
        .wr_fire(wr_fire),
        .rd_ok  (pace_rd_ok),
        .wr_ok  (pace_wr_ok)
    );

    mover_beat_buf #(
        .DATA_W(DATA_W), .DEPTH(BUF_DEPTH)
    ) i_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (inflight_q),
        .push_data(sp_rd_data),
        .pop      (wr_fire & reads_sp),
        .head     (buf_head),
        .count    (buf_cnt)
    );

    // Transfer state: load on launch, then step the pointers on each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            dir_q      <= DIR_ZERO_TO_SP;
            rd_addr_q  <= '0;
            wr_unit_q  <= '0;
            win_addr_q <= '0;
            rd_left_q  <= '0;
            wr_left_q  <= '0;
            inflight_q <= 1'b0;
        end else if (launch) begin
            busy_q     <= 1'b1;
            dir_q      <= start_kind;
            rd_addr_q  <= start_src;
            wr_unit_q  <= start_dst;
            win_addr_q <= map_base;
            rd_left_q  <= start_size;
            wr_left_q  <= start_size;
            inflight_q <= 1'b0;
        end else begin
            inflight_q <= rd_fire;
            if (rd_fire) begin
                rd_addr_q <= rd_addr_q + 1'b1;
                rd_left_q <= rd_left_q - 1'b1;
            end
            if (wr_fire) begin
                wr_unit_q  <= wr_unit_q + 1'b1;
                win_addr_q <= win_addr_q + ADDR_W'(16);
                wr_left_q  <= wr_left_q - 1'b1;
            end
            if (last_wr) busy_q <= 1'b0;
        end
    end

    assign start_ready = ~busy_q;
    assign busy        = busy_q;
    assign outstanding = inflight_q | (buf_cnt != '0);
    assign sp_rd_req   = rd_go;
    assign sp_rd_addr  = rd_addr_q;
    assign sp_wr_req   = wr_go & ~to_win;
    assign sp_wr_addr  = wr_unit_q;
    assign sp_wr_data  = beat_data;
    assign win_wr_req  = wr_go & to_win;
    assign win_wr_addr = win_addr_q;
    assign win_wr_data = beat_data;
endmodule

// File: rtl/mover_checks.sv
// Protocol properties of the mover, attached to every instance by the bind below.
// Assumes the synchronous active-low reset clears the engine.
module mover_checks #(
    parameter int              UNIT_AW     = 16,
    parameter int              DATA_W      = 128,
    parameter int              ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] CFG_BASE    = 32'hFFEF_0000,
    parameter logic [ADDR_W-1:0] CFG_BYTES   = 32'h0001_0000,
    parameter logic [ADDR_W-1:0] IRAM_BASE   = 32'hFFC0_0000,
    parameter logic [ADDR_W-1:0] IRAM_OFFSET = 32'h0004_0000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_valid,
    input logic               start_ready,
    input logic               busy,
    input logic               outstanding,
    input logic               sp_gnt,
    input logic               sp_rd_req,
    input logic [UNIT_AW-1:0] sp_rd_addr,
    input logic               sp_wr_req,
    input logic [UNIT_AW-1:0] sp_wr_addr,
    input logic [DATA_W-1:0]  sp_wr_data,
    input logic               win_wr_req,
    input logic [ADDR_W-1:0]  win_wr_addr,
    input logic [DATA_W-1:0]  win_wr_data,
    input logic [1:0]         cur_dir
);
    localparam logic [ADDR_W-1:0] CFG_TOP  = CFG_BASE + (CFG_BYTES - 1);
    localparam logic [ADDR_W-1:0] SPAN     = ADDR_W'(1) << (UNIT_AW + 4);
    localparam logic [ADDR_W-1:0] IRAM_TOP = IRAM_BASE + (SPAN - IRAM_OFFSET);

    p_start_handshake_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_valid && start_ready));

    p_zero_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sp_rd_req |-> cur_dir[0]);

    p_zero_payload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((sp_wr_req || win_wr_req) && !cur_dir[0]) |-> (sp_wr_data == '0 && win_wr_data == '0));

    p_window_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_wr_req |-> ((win_wr_addr >= CFG_BASE && win_wr_addr <= CFG_TOP) ||
                        (win_wr_addr >= IRAM_BASE && win_wr_addr < IRAM_TOP)));

    p_window_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr_req && $past(win_wr_req)) |-> (win_wr_addr == $past(win_wr_addr) + ADDR_W'(16)));

    p_read_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_rd_req && !sp_gnt) |=> (sp_rd_req && $stable(sp_rd_addr)));

    p_write_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_wr_req && !sp_gnt) |=> (sp_wr_req && $stable(sp_wr_addr) && $stable(sp_wr_data)));

    p_read_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_rd_req && sp_gnt) |=> outstanding);

    p_drained_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !outstanding);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(sp_rd_req || sp_wr_req || win_wr_req));
endmodule

bind zfill_copy_mover mover_checks #(
    .UNIT_AW(UNIT_AW), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE),
    .CFG_BYTES(CFG_BYTES), .IRAM_BASE(IRAM_BASE), .IRAM_OFFSET(IRAM_OFFSET)
) i_checks (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .busy(busy), .outstanding(outstanding), .sp_gnt(sp_gnt),
    .sp_rd_req(sp_rd_req), .sp_rd_addr(sp_rd_addr),
    .sp_wr_req(sp_wr_req), .sp_wr_addr(sp_wr_addr), .sp_wr_data(sp_wr_data),
    .win_wr_req(win_wr_req), .win_wr_addr(win_wr_addr), .win_wr_data(win_wr_data),
    .cur_dir(dir_q)
);

// File: tb/test_zfill_copy_mover.sv
// Bench: a behavioural reference model is stepped every cycle and compared with all outputs.
// The scratchpad is modelled as a sparse memory with registered read data.
module test_zfill_copy_mover;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_valid = 1'b0;
    logic         start_ready;
    logic [15:0]  start_src = '0, start_dst = '0, start_size = '0;
    logic [1:0]   start_dir = '0;
    logic         sp_gnt = 1'b1;
    logic         sp_rd_req, sp_wr_req, win_wr_req, busy, outstanding;
    logic [15:0]  sp_rd_addr, sp_wr_addr;
    logic [127:0] sp_rd_data = '0, sp_wr_data, win_wr_data;
    logic [31:0]  win_wr_addr;

    always #5 clk = ~clk;

    zfill_copy_mover i_zfill_copy_mover (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
        .start_src(start_src), .start_dst(start_dst), .start_size(start_size),
        .start_dir(start_dir), .sp_gnt(sp_gnt), .sp_rd_req(sp_rd_req),
        .sp_rd_addr(sp_rd_addr), .sp_rd_data(sp_rd_data), .sp_wr_req(sp_wr_req),
        .sp_wr_addr(sp_wr_addr), .sp_wr_data(sp_wr_data), .win_wr_req(win_wr_req),
        .win_wr_addr(win_wr_addr), .win_wr_data(win_wr_data), .busy(busy),
        .outstanding(outstanding)
    );

    int n_checks = 0;
    int n_errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] pat(input int a);
        logic [31:0] u = 32'(a);
        return {u * 32'h9E37_79B1, ~u, u ^ 32'h5A5A_0000, u + 32'h1234};
    endfunction

    // Scratchpad memory model.
    logic [127:0] sp_mem [int];
    function automatic logic [127:0] sp_read(input int a);
        return sp_mem.exists(a) ? sp_mem[a] : pat(a);
    endfunction

    int          n_sp_wr = 0, n_win = 0;
    logic [31:0] win_first = '0;

    // Memory side: registered read data, writes on grant, window write log.
    always @(posedge clk) begin
        if (sp_rd_req && sp_gnt) sp_rd_data <= sp_read(int'(sp_rd_addr));
        if (sp_wr_req && sp_gnt) begin
            sp_mem[int'(sp_wr_addr)] = sp_wr_data;
            n_sp_wr++;
        end
        if (win_wr_req) begin
            if (n_win == 0) win_first = win_wr_addr;
            n_win++;
        end
    end

    // Grant driver: 0 always granted, 1 pseudo-random, 2 never granted.
    int         gmode = 0;
    logic [7:0] lfsr = 8'hA5;
    always @(negedge clk) begin
        lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        sp_gnt <= (gmode == 0) ? 1'b1 : (gmode == 2) ? 1'b0 : lfsr[0];
    end

    // Reference model state.
    bit           m_busy = 0, m_infl = 0;
    logic [1:0]   m_dir = '0;
    int           m_rd_left = 0, m_wr_left = 0, m_fc = 0, m_rdc = 0, m_wrc = 0;
    int           m_rd_addr = 0, m_wr_unit = 0;
    logic [31:0]  m_win = '0;
    logic [127:0] m_infl_data = '0;
    logic [127:0] m_buf [$];

    // Model step: predict outputs from the state, compare them, then advance the state.
    always @(negedge clk) begin
        bit reads, win, e_rd, e_go, e_spw, e_win, rd_f, wr_f, old_busy;
        logic [127:0] e_data;
        #4;
        reads  = m_dir[0];
        win    = m_dir[0] ^ m_dir[1];
        e_rd   = m_busy && reads && m_rd_left > 0 && m_rdc < 8 && (m_buf.size() + int'(m_infl)) < 8;
        e_go   = m_busy && m_wr_left > 0 && (reads ? (m_buf.size() > 0 && m_wrc < 8) : 1'b1);
        e_spw  = e_go && !win;
        e_win  = e_go && win;
        e_data = (reads && m_buf.size() > 0) ? m_buf[0] : '0;

        chk(start_ready == !m_busy, "R1 start_ready", 128'(start_ready), 128'(!m_busy));
        chk(busy == m_busy, "R8 busy", 128'(busy), 128'(m_busy));
        chk(outstanding == (m_infl || m_buf.size() > 0), "R8 outstanding",
            128'(outstanding), 128'(m_infl || m_buf.size() > 0));
        chk(sp_rd_req == e_rd, "R6 sp_rd_req", 128'(sp_rd_req), 128'(e_rd));
        if (e_rd) chk(int'(sp_rd_addr) == m_rd_addr, "R6 sp_rd_addr", 128'(sp_rd_addr), 128'(m_rd_addr));
        chk(sp_wr_req == e_spw, "R2 sp_wr_req", 128'(sp_wr_req), 128'(e_spw));
        if (e_spw) begin
            chk(int'(sp_wr_addr) == m_wr_unit, "R2 sp_wr_addr", 128'(sp_wr_addr), 128'(m_wr_unit));
            chk(sp_wr_data == e_data, "R6 sp_wr_data", sp_wr_data, e_data);
        end
        chk(win_wr_req == e_win, "R3 win_wr_req", 128'(win_wr_req), 128'(e_win));
        if (e_win) begin
            chk(win_wr_addr == m_win, "R4 win_wr_addr", 128'(win_wr_addr), 128'(m_win));
            chk(win_wr_data == e_data, "R2 win_wr_data", win_wr_data, e_data);
        end

        if (!rst_n) begin
            m_busy = 0; m_infl = 0; m_dir = '0; m_buf.delete();
            m_rd_left = 0; m_wr_left = 0; m_fc = 0; m_rdc = 0; m_wrc = 0;
        end else begin
            old_busy = m_busy;
            rd_f = e_rd && sp_gnt;
            wr_f = e_win || (e_spw && sp_gnt);
            if (wr_f) begin
                if (reads) void'(m_buf.pop_front());
                m_wr_left--; m_wr_unit++; m_win = m_win + 32'd16;
                if (m_wr_left == 0) m_busy = 0;
            end
            if (m_infl) m_buf.push_back(m_infl_data);
            m_infl = rd_f;
            if (rd_f) begin
                m_infl_data = sp_read(m_rd_addr);
                m_rd_addr++; m_rd_left--;
            end
            if (old_busy && reads) begin
                if (m_fc == 10) begin
                    m_fc = 0; m_rdc = 0; m_wrc = 0;
                end else begin
                    m_fc++; m_rdc += int'(rd_f); m_wrc += int'(wr_f);
                end
            end
            if (start_valid && !old_busy) begin
                bit w_dir, lo, hi;
                w_dir = start_dir[0] ^ start_dir[1];
                lo = start_dst <= 16'h0FFF;
                hi = start_dst >= 16'h4000;
                if (start_size != 0 && !(w_dir && !lo && !hi)) begin
                    m_busy = 1; m_dir = start_dir; m_infl = 0; m_buf.delete();
                    m_rd_left = int'(start_size); m_wr_left = int'(start_size);
                    m_rd_addr = int'(start_src); m_wr_unit = int'(start_dst);
                    m_fc = 0; m_rdc = 0; m_wrc = 0;
                    m_win = lo ? 32'hFFEF_0000 + {12'h0, start_dst, 4'h0}
                               : 32'hFFC0_0000 + {12'h0, start_dst, 4'h0} - 32'h0004_0000;
                end
            end
        end
    end

    // Start one transfer and count the cycles busy stays high.
    task automatic run_xfer(input int src, input int dst, input int size, input int dir,
                            input bit junk, output int cyc);
        @(negedge clk);
        start_valid = 1'b1; start_src = 16'(src); start_dst = 16'(dst);
        start_size = 16'(size); start_dir = 2'(dir);
        @(posedge clk); #1;
        if (junk) begin
            start_src = 16'h0; start_dst = 16'h0700; start_size = 16'd4; start_dir = 2'd0;
        end else begin
            start_valid = 1'b0;
        end
        cyc = 0;
        while (busy && cyc < 5000) begin
            cyc++;
            if (cyc == 4) start_valid = 1'b0;
            @(posedge clk); #1;
        end
        start_valid = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    task automatic clear_logs();
        n_sp_wr = 0; n_win = 0; win_first = '0;
    endtask

    initial begin
        int cyc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk(start_ready == 1'b1 && busy == 1'b0 && outstanding == 1'b0, "R1 reset state",
            128'({start_ready, busy, outstanding}), 128'(3'b100));

        // R6 paced copy, with a start held during busy that must be ignored (R1).
        gmode = 0; clear_logs();
        run_xfer(16'h100, 16'h400, 20, 3, 1'b1, cyc);
        chk(cyc == 28, "R6 busy cycles for 20-beat copy", 128'(cyc), 128'(28));
        for (int i = 0; i < 20; i++)
            chk(sp_read(16'h400 + i) == pat(16'h100 + i), "R6 copied beat",
                sp_read(16'h400 + i), pat(16'h100 + i));
        chk(n_sp_wr == 20, "R1 ignored start adds no writes", 128'(n_sp_wr), 128'(20));

        // R10 scratchpad zero-fill, one beat per cycle; R2 zeros written.
        clear_logs();
        run_xfer(0, 16'h400, 5, 0, 1'b0, cyc);
        chk(cyc == 5, "R10 zero-fill cycles", 128'(cyc), 128'(5));
        for (int i = 0; i < 5; i++)
            chk(sp_read(16'h400 + i) == '0, "R2 zero-filled beat", sp_read(16'h400 + i), '0);
        chk(sp_read(16'h405) == pat(16'h105), "R2 beat past fill untouched",
            sp_read(16'h405), pat(16'h105));

        // R7 copy under a toggling grant.
        gmode = 1; clear_logs();
        run_xfer(16'h200, 16'h600, 13, 3, 1'b0, cyc);
        for (int i = 0; i < 13; i++)
            chk(sp_read(16'h600 + i) == pat(16'h200 + i), "R7 copy under stalls",
                sp_read(16'h600 + i), pat(16'h200 + i));

        // R3 copy into the configuration region.
        gmode = 0; clear_logs();
        run_xfer(16'h300, 16'h0010, 10, 1, 1'b0, cyc);
        chk(n_win == 10, "R3 window beat count", 128'(n_win), 128'(10));
        chk(win_first == 32'hFFEF_0100, "R3 first cfg address", 128'(win_first), 128'(32'hFFEF_0100));
        chk(cyc == 15, "R6 busy cycles for 10-beat copy", 128'(cyc), 128'(15));
        chk(n_sp_wr == 0, "R2 window copy writes no scratchpad", 128'(n_sp_wr), 128'(0));

        // R3 top unit of the configuration region.
        clear_logs();
        run_xfer(0, 16'h0FFF, 1, 2, 1'b0, cyc);
        chk(win_first == 32'hFFEF_FFF0, "R3 last cfg unit", 128'(win_first), 128'(32'hFFEF_FFF0));

        // R4 + R7 window zero-fill with the grant held low.
        gmode = 2; clear_logs();
        run_xfer(0, 16'h4002, 6, 2, 1'b0, cyc);
        chk(cyc == 6, "R7 window fill ignores grant", 128'(cyc), 128'(6));
        chk(n_win == 6, "R4 iram beat count", 128'(n_win), 128'(6));
        chk(win_first == 32'hFFC0_0020, "R4 first iram address", 128'(win_first), 128'(32'hFFC0_0020));

        gmode = 0; clear_logs();
        run_xfer(0, 16'h4000, 2, 2, 1'b0, cyc);
        chk(win_first == 32'hFFC0_0000, "R4 lowest iram unit", 128'(win_first), 128'(32'hFFC0_0000));

        // R5 destinations in the hole are dropped.
        clear_logs();
        run_xfer(16'h100, 16'h1000, 4, 1, 1'b0, cyc);
        chk(cyc == 0 && n_win == 0, "R5 hole low edge dropped", 128'(n_win + cyc), 128'(0));
        run_xfer(0, 16'h3FFF, 4, 2, 1'b0, cyc);
        chk(cyc == 0 && n_win == 0, "R5 hole high edge dropped", 128'(n_win + cyc), 128'(0));
        chk(start_ready == 1'b1, "R5 ready after drop", 128'(start_ready), 128'(1));

        // R9 zero size.
        clear_logs();
        run_xfer(16'h100, 16'h500, 0, 3, 1'b0, cyc);
        chk(cyc == 0 && n_sp_wr == 0, "R9 zero size no traffic", 128'(n_sp_wr + cyc), 128'(0));
        chk(outstanding == 1'b0, "R8 nothing outstanding when idle", 128'(outstanding), 128'(0));

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R8 watchdog expired: actual busy %0d expected idle", busy);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule